// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block derives the timing strobes for an asynchronous serial port from a fast core clock. The core clock is first divided by a fixed ratio (four by default) to form a bus-rate tick. A one-byte rate register then selects two cascaded dividers that act on that bus tick. The first is a prescaler with the uneven ratios 1, 3, 4 and 13. The second is a binary divider of 1 to 128. Together they set the oversampling strobe. Every sixteenth oversampling strobe also raises the bit strobe, so one bit lasts prescale × 16 × 2^rate bus clocks.

The register is written and read back through a simple byte port. A write restarts every counter, so the first strobes after a rate change arrive one full period after the write. At reset the register takes one of two values. It is cleared to zero in normal operation. In bootstrap mode it takes a preset value that selects a usable default rate: prescale 13, binary divide 8, which gives roughly 1200 bit/s from a 2 MHz bus clock. Two test bits and one spare bit are stored and read back but do not affect timing.

Top module: `sci_baud_gen`

## Requirements
- R1: While `rst_n` is low with `boot_mode` low, `rate_q` reads 0x00 and neither strobe is asserted.
- R2: While `rst_n` is low with `boot_mode` high, `rate_q` reads 0x33, and after reset the bit strobe period is CORE_DIV × 16 × 13 × 8 core cycles.
- R3: A write with `wr_en` stores all eight bits of `wr_data`, and the value appears on `rate_q` in the cycle after the write edge. Without a write, `rate_q` holds its value.
- R4: Bits 5:4 select the prescaler: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R5: Bits 2:0 hold a value r. The oversampling strobe `samp_en` then recurs every CORE_DIV × prescale × 2^r core cycles.
- R6: `bit_en` is asserted only together with `samp_en`, on every sixteenth oversampling strobe. Its period is sixteen oversampling periods.
- R7: A write restarts all dividers. Neither strobe is asserted in the cycle after the write. The first `samp_en` comes one oversampling period after the write edge, and the first `bit_en` comes one bit period after it.
- R8: Bits 7, 6 and 3 (two test bits and a spare) are stored but have no effect on either strobe period.
- R9: With CORE_DIV of 2 or more, each strobe is high for a single core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 1 | Selects the bootstrap reset value while reset is held |
| wr_en | input | 1 | Rate register write strobe |
| wr_data | input | 8 | Rate register write data |
| rate_q | output | 8 | Rate register read-back |
| samp_en | output | 1 | One-cycle oversampling strobe |
| bit_en | output | 1 | One-cycle bit strobe |

## Verification
Each write lands on an edge, and the read-back is due one step after that edge. The first `samp_en` is due exactly CORE_DIV × prescale × 2^r edges later, and the first `bit_en` sixteen times as many edges later. The next strobe then arrives after the same number of edges again. The bench drives writes at the falling edge, counts rising edges from the write edge, and samples the outputs a little after each rising edge. The count at which a strobe is first seen high must therefore equal the computed period exactly, with no tolerance.

// File: rtl/sci_baud_gen.sv
module sci_baud_gen #(
  parameter int CORE_DIV = 4,
  parameter int OVS      = 16,
  parameter logic [7:0] BOOT_VAL = 8'h33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rate_q,
  output logic       samp_en,
  output logic       bit_en
);
  localparam int CDW   = (CORE_DIV > 1) ? $clog2(CORE_DIV) : 1;
  localparam int OVW   = $clog2(OVS);
  localparam int MAXSP = CORE_DIV * 13 * 128;

  logic [7:0]     reg_q;
  logic [3:0]     pre_cnt, pre_m1;
  logic [6:0]     rate_cnt, rate_m1;
  logic [OVW-1:0] ovs_cnt;
  logic           bus_tick, samp_hit;

  assign rate_q = reg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     reg_q <= boot_mode ? BOOT_VAL : 8'h00;
    else if (wr_en) reg_q <= wr_data;

  generate
    if (CORE_DIV > 1) begin : g_cdiv
      logic [CDW-1:0] cdiv;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                              cdiv <= '0;
        else if (wr_en || cdiv == CDW'(CORE_DIV-1)) cdiv <= '0;
        else                                     cdiv <= cdiv + 1'b1;
      assign bus_tick = !wr_en && (cdiv == CDW'(CORE_DIV-1));
    end else begin : g_nodiv
      assign bus_tick = !wr_en;
    end
  endgenerate

  always_comb
    case (reg_q[5:4])
      2'b00:   pre_m1 = 4'd0;
      2'b01:   pre_m1 = 4'd2;
      2'b10:   pre_m1 = 4'd3;
      default: pre_m1 = 4'd12;
    endcase

  assign rate_m1  = 7'((8'd1 << reg_q[2:0]) - 8'd1);
  assign samp_hit = bus_tick && pre_cnt == pre_m1 && rate_cnt == rate_m1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      ovs_cnt  <= '0;
      samp_en  <= 1'b0;
      bit_en   <= 1'b0;
    end else if (wr_en) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      ovs_cnt  <= '0;
      samp_en  <= 1'b0;
      bit_en   <= 1'b0;
    end else begin
      samp_en <= samp_hit;
      bit_en  <= samp_hit && ovs_cnt == OVW'(OVS-1);
      if (bus_tick) begin
        if (pre_cnt == pre_m1) begin
          pre_cnt <= '0;
          rate_cnt <= (rate_cnt == rate_m1) ? '0 : rate_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
      if (samp_hit) ovs_cnt <= ovs_cnt + 1'b1;
    end

  int unsigned gap;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                gap <= 0;
    else if (wr_en || samp_en) gap <= 0;
    else                       gap <= gap + 1;

  // R3
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rate_q == $past(wr_data));
  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rate_q));
  // R6
  bit_in_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> samp_en);
  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !samp_en && !bit_en);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CORE_DIV > 1 && samp_en) |=> !samp_en);
  // R5
  samp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= MAXSP);
endmodule

// File: tb/sci_baud_gen_tb.sv
module sci_baud_gen_tb;
  localparam int CLK_T = 10;
  localparam int CDIV  = 4;
  localparam int WDOG  = 190000;

  logic clk = 0, rst_n = 0, boot_mode = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rate_q;
  logic samp_en, bit_en;
  int checks = 0, errors = 0, cyc_total = 0;
  bit timed_out = 0;

  sci_baud_gen #(.CORE_DIV(CDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rate_q(rate_q), .samp_en(samp_en), .bit_en(bit_en));

  always #(CLK_T/2) clk = ~clk;
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == WDOG) timed_out = 1;
  end

  function automatic int presc(input logic [7:0] v);
    case (v[5:4]) 2'b00: return 1; 2'b01: return 3; 2'b10: return 4; default: return 13; endcase
  endfunction
  function automatic int samp_per(input logic [7:0] v);
    return CDIV * presc(v) * (1 << v[2:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic wait_sig(input bit use_bit, input int limit, output int cyc, output int samps);
    cyc = 0; samps = 0;
    while (cyc < limit && !timed_out) begin
      @(posedge clk); cyc++; #1;
      if (samp_en) samps++;
      if (use_bit ? bit_en : samp_en) break;
    end
  endtask

  int c, s, p;
  logic [7:0] v;

  initial begin
    void'($urandom(32'h5eed_1234));
    boot_mode = 1; rst_n = 0;
    repeat (3) @(posedge clk); #1;
    // R2
    chk(rate_q == 8'h33, "R2 boot value", rate_q, 8'h33);
    @(negedge clk); rst_n = 1;
    wait_sig(1, 20000, c, s);
    wait_sig(1, 20000, c, s);
    // R2 steady boot rate
    chk(c == CDIV*16*13*8, "R2 boot bit period", c, CDIV*16*13*8);

    @(negedge clk); boot_mode = 0; rst_n = 0;
    @(posedge clk); #1;
    // R1
    chk(rate_q == 8'h00, "R1 reset value", rate_q, 0);
    chk(!samp_en && !bit_en, "R1 strobes low", {samp_en, bit_en}, 0);
    @(negedge clk); rst_n = 1;

    // R4 R5 R7: every combination, first sample strobe after write
    for (int ps = 0; ps < 4; ps++)
      for (int r = 0; r < 8; r++) begin
        v = {2'b00, 2'(ps), 1'b0, 3'(r)};
        do_write(v);
        // R3
        chk(rate_q == v, "R3 read-back", rate_q, v);
        chk(!samp_en && !bit_en, "R7 quiet after write", {samp_en, bit_en}, 0);
        p = samp_per(v);
        wait_sig(0, p + 10, c, s);
        chk(c == p, "R4 R5 R7 sample period", c, p);
        if (CDIV > 1) begin
          @(posedge clk); #1;
          // R9
          chk(!samp_en, "R9 single-cycle sample", samp_en, 0);
        end
      end

    // R6 R7: bit period for low rate selects
    for (int ps = 0; ps < 4; ps++)
      for (int r = 0; r < 4; r++) begin
        v = {2'b00, 2'(ps), 1'b0, 3'(r)};
        do_write(v);
        p = 16 * samp_per(v);
        wait_sig(1, p + 10, c, s);
        chk(c == p, "R7 first bit after write", c, p);
        chk(s == 16, "R6 samples per bit", s, 16);
        wait_sig(1, p + 10, c, s);
        chk(c == p, "R6 bit period", c, p);
      end

    // R5 R6 slowest binary divide, prescale 1
    do_write(8'h07);
    wait_sig(1, 9000, c, s);
    chk(c == 16*samp_per(8'h07), "R6 rate 7 bit period", c, 16*samp_per(8'h07));

    // R8: test and spare bits set, timing unchanged
    do_write(8'hC9);
    chk(rate_q == 8'hC9, "R8 test bits stored", rate_q, 8'hC9);
    wait_sig(1, 5000, c, s);
    chk(c == 16*samp_per(8'h09), "R8 test bits no effect", c, 16*samp_per(8'h09));

    // R3 register holds with no write
    repeat (20) @(posedge clk); #1;
    chk(rate_q == 8'hC9, "R3 hold", rate_q, 8'hC9);

    // random: mixed values, small rate selects
    for (int i = 0; i < 12; i++) begin
      v = 8'($urandom);
      v[2] = 1'b0;
      do_write(v);
      chk(rate_q == v, "R3 random read-back", rate_q, v);
      p = samp_per(v);
      wait_sig(0, p + 10, c, s);
      chk(c == p, "R5 random first sample", c, p);
      wait_sig(0, p + 10, c, s);
      chk(c == p, "R5 random sample period", c, p);
    end

    // R7: write mid-period restarts the count
    do_write(8'h32);
    repeat (37) @(posedge clk);
    do_write(8'h01);
    wait_sig(0, 100, c, s);
    chk(c == samp_per(8'h01), "R7 restart mid-period", c, samp_per(8'h01));

    if (timed_out) chk(0, "watchdog", cyc_total, WDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule